// File: doc/BRIEF.md
# Booth Radix-2 Sequential Signed Multiplier

This block forms the signed product of two two's-complement operands, each `WIDTH` bits wide, one multiplier bit per clock. The pair made of the current low multiplier bit and the bit shifted out in the step before picks one of three actions for the partial product: add the multiplicand, subtract it, or leave it alone. The accumulator, multiplier register and extension bit then shift right together as one arithmetic chain. After `WIDTH` steps the full `2*WIDTH`-bit signed product is available.

The operand side works like a valid/ready input. `start` is the valid. `busy` is the inverse of ready. A pair is accepted only on a rising clock edge where `start` is high and `busy` is low. While `busy` is high, `start` and the operand pins are ignored and are not queued. The producer must hold its request until `busy` is low again. The result side has no back-pressure. `done` pulses for one cycle, and `product` then holds its value until the next operand pair is accepted. The accumulator carries one guard bit, so the most negative operand squared does not overflow.

Top module: `booth_mult`

## Requirements
- R1: While `rst_n` is low, and after it is released with no start, `busy` = 0, `done` = 0 and `product` = 0.
- R2: A start accepted at clock edge k (`start`=1, `busy`=0) sets `busy` to 1 after edge k.
- R3: `busy` stays high for exactly `WIDTH` cycles. `done` is 1 for exactly one cycle, starting right after edge k+`WIDTH`, and `busy` and `done` are never both 1.
- R4: When `done` is 1, `product` equals the signed value `mcand` × `mplier`, written in two's complement in `2*WIDTH` bits, for every pair of operand values.
- R5: A pair with a negative multiplier (MSB = 1), for example -9 × -13, gives the correct positive or negative product. For -9 × -13 that is +117.
- R6: The most negative operand times itself (-2^(WIDTH-1) squared) gives +2^(2*WIDTH-2), with no wrap in the accumulator.
- R7: A `start` pulse while `busy` is 1 has no effect. The operation in progress keeps its timing and its operands.
- R8: While idle and with no start, `product` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operand pair valid. Taken only while not busy |
| mcand | input | WIDTH | Multiplicand, two's complement |
| mplier | input | WIDTH | Multiplier, two's complement |
| busy | output | 1 | Operation in progress. The inverse of ready |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2*WIDTH | Signed product, held until the next accepted start |

## Verification
A wrong recode decision, a lost sign bit in the arithmetic shift, or a missing guard bit shows up as a wrong `product` in the cycle where `done` first rises. That is `WIDTH` cycles after the start. Sweeping every operand pair of a small width finds each of these faults. An off-by-one in the step counter moves `done` one cycle early or late, or makes its pulse longer. The port-level timing checks see this in the same operation. Accepting a second start during `busy` corrupts the product of the operation already running.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    BOP_KEEP = 2'd0,
    BOP_ADD  = 2'd1,
    BOP_SUB  = 2'd2
  } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      cur_bit,
  input  logic      prev_bit,
  output booth_op_e op
);
  // 10: start of a run of ones -> subtract; 01: end of run -> add
  always_comb begin
    unique case ({cur_bit, prev_bit})
      2'b10:   op = BOP_SUB;
      2'b01:   op = BOP_ADD;
      default: op = BOP_KEEP;
    endcase
  end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int W = 9
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] mcand,
  input  booth_op_e    op,
  output logic [W-1:0] sum
);
  always_comb begin
    unique case (op)
      BOP_ADD: sum = acc + mcand;
      BOP_SUB: sum = acc + (~mcand) + W'(1);
      default: sum = acc;
    endcase
  end
endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
  parameter int STEPS = 8,
  localparam int CW = $clog2(STEPS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  logic [CW-1:0] sc;

  assign load = start & ~busy;
  assign step = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc   <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        sc   <= CW'(STEPS);
        busy <= 1'b1;
      end else if (busy) begin
        sc <= sc - CW'(1);
        if (sc == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/booth_mult.sv
module booth_mult
  import booth_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int AW = WIDTH + 1,
  localparam int PW = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] mcand,
  input  logic [WIDTH-1:0] mplier,
  output logic             busy,
  output logic             done,
  output logic [PW-1:0]    product
);
  logic [AW-1:0]    br_q;   // sign-extended multiplicand
  logic [AW-1:0]    ac_q;   // accumulator with guard bit
  logic [WIDTH-1:0] qr_q;
  logic             qx_q;
  logic [AW-1:0]    sum;
  booth_op_e        op;
  logic             load, step;

  booth_seq_ctrl #(.STEPS(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load(load), .step(step), .busy(busy), .done(done)
  );

  booth_recode u_rec (.cur_bit(qr_q[0]), .prev_bit(qx_q), .op(op));

  booth_addsub #(.W(AW)) u_as (.acc(ac_q), .mcand(br_q), .op(op), .sum(sum));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      br_q <= '0;
      ac_q <= '0;
      qr_q <= '0;
      qx_q <= 1'b0;
    end else if (load) begin
      br_q <= {mcand[WIDTH-1], mcand};
      ac_q <= '0;
      qr_q <= mplier;
      qx_q <= 1'b0;
    end else if (step) begin
      ac_q <= {sum[AW-1], sum[AW-1:1]};
      qr_q <= {sum[0], qr_q[WIDTH-1:1]};
      qx_q <= qr_q[0];
    end
  end

  assign product = {ac_q[WIDTH-1:0], qr_q};
endmodule

// File: rtl/booth_mult_chk.sv
module booth_mult_chk #(
  parameter int WIDTH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [2*WIDTH-1:0] product
);
  logic [15:0] busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 16'd1;
    else busy_cnt <= '0;
  end

  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r3_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == 16'(WIDTH)));
  a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));
endmodule

bind booth_mult booth_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .product(product)
);

// File: tb/sim_booth_mult.sv
module sim_booth_mult;
  localparam int CLK_PERIOD = 10;
  localparam int W = 6;
  localparam int PW = 2 * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] mcand = '0, mplier = '0;
  logic busy, done;
  logic [PW-1:0] product;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  booth_mult #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .product(product)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // run one op; optionally pulse a disturbing start mid-operation (R7)
  task automatic run_op(input int a, input int b, input bit disturb, input string req);
    logic [PW-1:0] exp;
    exp = PW'(a * b);
    @(negedge clk);
    mcand = W'(a); mplier = W'(b); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", longint'(busy), 1);
    for (int i = 1; i < W; i++) begin
      if (disturb && i == 2) begin
        mcand = W'(a + 1); mplier = W'(b - 1); start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b0 && busy == 1'b1, "R3", longint'({busy, done}), 2);
    end
    @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, "R3", longint'({busy, done}), 1);
    chk(product == exp, req, longint'(product), longint'(exp));
    @(negedge clk);
    chk(done == 1'b0, "R3", longint'(done), 0);
    chk(product == exp, "R8", longint'(product), longint'(exp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && product == 0, "R1", longint'(product), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 0 && done == 0 && product == 0, "R1", longint'(product), 0);

    run_op(-9, -13, 1'b0, "R5");
    run_op(-(1 << (W-1)), -(1 << (W-1)), 1'b0, "R6");
    run_op(-(1 << (W-1)), (1 << (W-1)) - 1, 1'b0, "R6");
    run_op(7, -5, 1'b1, "R7");
    run_op(-20, 13, 1'b1, "R7");
    repeat (4) @(negedge clk);
    chk(product == PW'(-20 * 13), "R8", longint'(product), longint'(PW'(-20 * 13)));

    for (int a = -(1 << (W-1)); a < (1 << (W-1)); a++)
      for (int b = -(1 << (W-1)); b < (1 << (W-1)); b++)
        run_op(a, b, 1'b0, "R4");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule